// File: doc/BRIEF.md
# Descriptor-List Playback Fetch Sequencer

This block feeds one playback channel by walking a ring of period descriptors in host memory. Each descriptor is two 32-bit words. The first word is the start address of the period's samples. The second word carries the period length in bytes in its upper half-word. Once the start control goes high, the block reads the descriptor selected by its list index. It then reads the period's sample words one at a time and passes each word to a sample stream. When the period is used up, it steps to the next descriptor and wraps back to entry zero after the last entry.

As the byte position inside a period advances, the block raises five events into a pending register: half period, full period, half buffer, full buffer, and end of audio. Software clears pending bits by writing ones. A mask selects which pending bits drive the registered interrupt line. An optional stop mode halts fetching at a chosen byte position inside a period.

The memory side is a request port and a response port, both valid/ready. Only one read is outstanding at a time. A request stays asserted with a stable address until it is accepted. The sample output is also valid/ready, and a data response is held at the memory port until the sample stream accepts it. Back-pressure on the sample stream therefore stalls the whole fetch chain without any storage inside the block.

Top module: `pdma_playback_seq`

## Requirements
- R1: While reset is asserted, the pending register, the interrupt, the list index, the byte position and the memory request valid are all zero.
- R2: On start, the block reads the descriptor at list base + 8 × list index. The sample address word is read first, then the word at +4, whose bits [31:16] give the period length in bytes; bits [15:0] of that word are ignored.
- R3: Sample words are requested at period address + byte position, with at most one read outstanding. Each data response appears unchanged on the sample stream, and the byte position grows by 4 for each accepted sample.
- R4: A memory request that is not yet accepted keeps its valid high and its address unchanged. During the data phase, a memory response is accepted only in the cycle the sample stream accepts it.
- R5: Pending bit 0 (half period) is set when an accepted sample brings the byte position to half the period length.
- R6: Pending bit 4 (full period) is set when an accepted sample completes the period. In that same cycle the byte position returns to 0, the list index advances, and the next descriptor fetch begins.
- R7: The list index wraps to 0 after entry list length − 1. Completing entry (list length / 2) − 1 sets pending bit 8 (half buffer). Completing the last entry sets pending bit 12 (full buffer).
- R8: With stop mode on, the accepted sample that brings the byte position to the stop position sets pending bit 24 (end of audio). No further memory request is made until start goes low.
- R9: In a cycle with the clear strobe, each pending bit whose clear-data bit is 1 is cleared and the others are kept. An event arriving in the same cycle wins over the clear.
- R10: The interrupt is a register. It equals the OR of pending AND mask as they stood one cycle earlier.
- R11: When start goes low, the block finishes the read in flight and then makes no further memory request. The list index and byte position are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_start | input | 1 | run control, level |
| cfg_list_base | input | 32 | byte address of descriptor entry 0 |
| cfg_list_len | input | 6 | number of descriptor entries |
| cfg_stop_en | input | 1 | enable halt at the stop position |
| cfg_end_addr | input | 16 | stop byte position inside a period |
| cfg_mask | input | 32 | interrupt mask, same bit layout as pending |
| pend_clr_we | input | 1 | clear strobe for the pending register |
| pend_clr_data | input | 32 | write-one-to-clear bits |
| mrq_valid | output | 1 | memory read request valid |
| mrq_ready | input | 1 | memory read request accepted |
| mrq_addr | output | 32 | memory read byte address |
| mrsp_valid | input | 1 | memory response valid |
| mrsp_ready | output | 1 | memory response accepted |
| mrsp_data | input | 32 | memory response word |
| smp_valid | output | 1 | sample word valid |
| smp_ready | input | 1 | sample word accepted |
| smp_data | output | 32 | sample word |
| list_ptr | output | 6 | current descriptor index |
| byte_ptr | output | 16 | byte position inside the current period |
| pend | output | 32 | pending events |
| irq | output | 1 | registered interrupt |

## Verification
The hardest case to reach is the cycle where a period boundary, a buffer wrap and a pending clear all land on the same clock edge. At that edge, set-over-clear priority, the byte position returning to zero and the list index wrap all interact. The stimulus uses four entries of alternating 64- and 128-byte periods and runs through two full passes of the ring. Ready signals on the memory and sample sides toggle pseudo-randomly, and clear strobes with random data arrive every fifth cycle, so the boundaries drift across many alignments. A model in the bench follows every accepted sample and compares the pending register on every cycle. Two further runs cover the stop position, and start being dropped in the middle of a period.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  // event indices inside the internal event vector
  localparam int EV_N  = 5;
  localparam int EV_HP = 0;
  localparam int EV_FP = 1;
  localparam int EV_HB = 2;
  localparam int EV_FB = 3;
  localparam int EV_EA = 4;

  // bit position of each event in the pending / mask layout
  localparam int EV_POS [EV_N] = '{0, 4, 8, 12, 24};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_D0_REQ,
    ST_D0_WAIT,
    ST_D1_REQ,
    ST_D1_WAIT,
    ST_S_REQ,
    ST_S_WAIT,
    ST_HALT
  } seq_state_t;

  function automatic logic [31:0] ev_layout_mask();
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < EV_N; k++) m[EV_POS[k]] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pdma_evdet.sv
module pdma_evdet
  import pdma_pkg::*;
#(
  parameter int PW    = 16,
  parameter int LW    = 6,
  parameter int BYTES = 4
) (
  input  logic          hs,
  input  logic [PW-1:0] bptr,
  input  logic [PW-1:0] size,
  input  logic [LW-1:0] lptr,
  input  logic [LW-1:0] len,
  input  logic          stop_en,
  input  logic [PW-1:0] end_addr,
  output logic [PW-1:0] nptr,
  output logic          period_done,
  output logic [LW-1:0] next_lptr,
  output logic [EV_N-1:0] ev
);

  logic          last_entry;
  logic          half_entry;
  logic [LW-1:0] half_idx;

  always_comb begin
    nptr        = bptr + PW'(BYTES);
    period_done = hs && (nptr >= size) && (size != '0);
    last_entry  = (len == '0) || (lptr >= len - LW'(1));
    half_idx    = (len >> 1) - LW'(1);
    half_entry  = (len >= LW'(2)) && (lptr == half_idx);
    next_lptr   = last_entry ? '0 : lptr + LW'(1);

    ev         = '0;
    ev[EV_HP]  = hs && (nptr == (size >> 1));
    ev[EV_FP]  = period_done;
    ev[EV_HB]  = period_done && half_entry;
    ev[EV_FB]  = period_done && last_entry;
    ev[EV_EA]  = hs && stop_en && (nptr == end_addr);
  end

endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] list_base,
  input  logic [LW-1:0] list_len,
  input  logic          stop_en,
  input  logic [PW-1:0] end_addr,
  output logic          mrq_valid,
  input  logic          mrq_ready,
  output logic [AW-1:0] mrq_addr,
  input  logic          mrsp_valid,
  output logic          mrsp_ready,
  input  logic [DW-1:0] mrsp_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_data,
  output logic [LW-1:0] list_ptr,
  output logic [PW-1:0] byte_ptr,
  output logic [EV_N-1:0] ev
);

  localparam int BYTES     = DW / 8;
  localparam int DESC_SHIFT = $clog2(2 * BYTES);

  seq_state_t    st_q, st_d;
  logic [AW-1:0] dma_q, dma_d;
  logic [PW-1:0] size_q, size_d;
  logic [PW-1:0] bptr_q, bptr_d;
  logic [LW-1:0] lptr_q, lptr_d;

  logic [AW-1:0] desc_addr;
  logic          data_hs;
  logic [PW-1:0] nptr;
  logic          period_done;
  logic [LW-1:0] next_lptr;

  // memory and sample handshakes
  always_comb begin
    desc_addr  = list_base + (AW'(lptr_q) << DESC_SHIFT);
    mrq_valid  = (st_q == ST_D0_REQ) || (st_q == ST_D1_REQ) || (st_q == ST_S_REQ);
    unique case (st_q)
      ST_D1_REQ: mrq_addr = desc_addr + AW'(BYTES);
      ST_S_REQ:  mrq_addr = dma_q + AW'(bptr_q);
      default:   mrq_addr = desc_addr;
    endcase
    smp_valid  = (st_q == ST_S_WAIT) && mrsp_valid;
    smp_data   = mrsp_data;
    mrsp_ready = (st_q == ST_D0_WAIT) || (st_q == ST_D1_WAIT) ||
                 ((st_q == ST_S_WAIT) && smp_ready);
    data_hs    = smp_valid && smp_ready;
  end

  pdma_evdet #(
    .PW    (PW),
    .LW    (LW),
    .BYTES (BYTES)
  ) u_evdet (
    .hs          (data_hs),
    .bptr        (bptr_q),
    .size        (size_q),
    .lptr        (lptr_q),
    .len         (list_len),
    .stop_en     (stop_en),
    .end_addr    (end_addr),
    .nptr        (nptr),
    .period_done (period_done),
    .next_lptr   (next_lptr),
    .ev          (ev)
  );

  always_comb begin
    st_d   = st_q;
    dma_d  = dma_q;
    size_d = size_q;
    bptr_d = bptr_q;
    lptr_d = lptr_q;
    unique case (st_q)
      ST_IDLE:    if (start) st_d = ST_D0_REQ;
      ST_D0_REQ:  if (mrq_ready) st_d = ST_D0_WAIT;
      ST_D0_WAIT: if (mrsp_valid) begin
        dma_d = mrsp_data[AW-1:0];
        st_d  = start ? ST_D1_REQ : ST_IDLE;
      end
      ST_D1_REQ:  if (mrq_ready) st_d = ST_D1_WAIT;
      ST_D1_WAIT: if (mrsp_valid) begin
        size_d = mrsp_data[DW-1 -: PW];
        st_d   = start ? ST_S_REQ : ST_IDLE;
      end
      ST_S_REQ:   if (mrq_ready) st_d = ST_S_WAIT;
      ST_S_WAIT:  if (data_hs) begin
        bptr_d = nptr;
        if (period_done) begin
          bptr_d = '0;
          lptr_d = next_lptr;
        end
        if (ev[EV_EA])        st_d = ST_HALT;
        else if (!start)      st_d = ST_IDLE;
        else if (period_done) st_d = ST_D0_REQ;
        else                  st_d = ST_S_REQ;
      end
      ST_HALT:    if (!start) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dma_q  <= '0;
      size_q <= '0;
      bptr_q <= '0;
      lptr_q <= '0;
    end else begin
      st_q   <= st_d;
      dma_q  <= dma_d;
      size_q <= size_d;
      bptr_q <= bptr_d;
      lptr_q <= lptr_d;
    end
  end

  assign list_ptr = lptr_q;
  assign byte_ptr = bptr_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrq_valid && !mrq_ready) |=> (mrq_valid && $stable(mrq_addr))); // R4

  AST_PTR_ZERO_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_FP] |=> (byte_ptr == '0)); // R6

  AST_WRAP_AT_FULL_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_FB] |=> (list_ptr == '0)); // R7

  AST_SILENT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_EA] |=> !mrq_valid); // R8

  AST_PTR_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_S_REQ) && (size_q != '0) && (size_q[5:0] == '0)) |-> (byte_ptr < size_q)); // R3

endmodule

// File: rtl/pdma_evt.sv
module pdma_evt
  import pdma_pkg::*;
#(
  parameter int RW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev,
  input  logic            clr_we,
  input  logic [RW-1:0]   clr_data,
  input  logic [RW-1:0]   mask,
  output logic [RW-1:0]   pend,
  output logic            irq
);

  localparam logic [RW-1:0] LAYOUT = RW'(ev_layout_mask());

  logic [RW-1:0] pend_q;
  logic [RW-1:0] set_v;
  logic [RW-1:0] clr_v;
  logic          irq_q;

  always_comb begin
    set_v = '0;
    for (int k = 0; k < EV_N; k++) set_v[EV_POS[k]] = ev[k];
    clr_v = clr_we ? clr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= ((pend_q & ~clr_v) | set_v) & LAYOUT;
      irq_q  <= |(pend_q & mask);
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;

  for (genvar k = 0; k < EV_N; k++) begin : g_chk
    localparam int P = EV_POS[k];

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_data[P] && !ev[k]) |=> !pend[P]); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev[k] |=> pend[P]); // R9

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[P] && !(clr_we && clr_data[P])) |=> pend[P]); // R9
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !irq); // R10

endmodule

// File: rtl/pdma_playback_seq.sv
module pdma_playback_seq
  import pdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic [AW-1:0] cfg_list_base,
  input  logic [LW-1:0] cfg_list_len,
  input  logic          cfg_stop_en,
  input  logic [PW-1:0] cfg_end_addr,
  input  logic [DW-1:0] cfg_mask,
  input  logic          pend_clr_we,
  input  logic [DW-1:0] pend_clr_data,
  output logic          mrq_valid,
  input  logic          mrq_ready,
  output logic [AW-1:0] mrq_addr,
  input  logic          mrsp_valid,
  output logic          mrsp_ready,
  input  logic [DW-1:0] mrsp_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_data,
  output logic [LW-1:0] list_ptr,
  output logic [PW-1:0] byte_ptr,
  output logic [DW-1:0] pend,
  output logic          irq
);

  logic [EV_N-1:0] ev;

  pdma_seq #(
    .AW (AW),
    .DW (DW),
    .PW (PW),
    .LW (LW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cfg_start),
    .list_base  (cfg_list_base),
    .list_len   (cfg_list_len),
    .stop_en    (cfg_stop_en),
    .end_addr   (cfg_end_addr),
    .mrq_valid  (mrq_valid),
    .mrq_ready  (mrq_ready),
    .mrq_addr   (mrq_addr),
    .mrsp_valid (mrsp_valid),
    .mrsp_ready (mrsp_ready),
    .mrsp_data  (mrsp_data),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .smp_data   (smp_data),
    .list_ptr   (list_ptr),
    .byte_ptr   (byte_ptr),
    .ev         (ev)
  );

  pdma_evt #(
    .RW (DW)
  ) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .clr_we   (pend_clr_we),
    .clr_data (pend_clr_data),
    .mask     (cfg_mask),
    .pend     (pend),
    .irq      (irq)
  );

  AST_REQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg_start) && !mrq_valid && !smp_valid) |=> !mrq_valid); // R11

endmodule

// File: tb/pdma_playback_seq_bench.sv
module pdma_playback_seq_bench;

  localparam logic [31:0] LBASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [31:0] cfg_list_base = LBASE;
  logic [5:0]  cfg_list_len = 6'd4;
  logic        cfg_stop_en = 1'b0;
  logic [15:0] cfg_end_addr = '0;
  logic [31:0] cfg_mask = '0;
  logic        pend_clr_we = 1'b0;
  logic [31:0] pend_clr_data = '0;
  logic        mrq_valid, mrq_ready = 1'b0;
  logic [31:0] mrq_addr;
  logic        mrsp_valid = 1'b0, mrsp_ready;
  logic [31:0] mrsp_data = '0;
  logic        smp_valid, smp_ready = 1'b0;
  logic [31:0] smp_data;
  logic [5:0]  list_ptr;
  logic [15:0] byte_ptr;
  logic [31:0] pend;
  logic        irq;

  always #10 clk = ~clk;

  pdma_playback_seq u_pdma_playback_seq (.*);

  int ntot = 0, nbad = 0, cyc = 0;
  logic [31:0] expq [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] psize(input int idx);
    return idx[0] ? 16'd128 : 16'd64;
  endfunction

  function automatic logic [31:0] pbase(input int idx);
    return 32'h0002_0000 + 32'(idx) * 32'h1000;
  endfunction

  function automatic logic [31:0] memf(input logic [31:0] a);
    if (a >= LBASE && a < LBASE + 32'd64) begin
      int idx = int'((a - LBASE) >> 3);
      if (a[2]) return {psize(idx), 16'h00AB};
      return pbase(idx);
    end
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
  endfunction

  task automatic push_periods(input int first, input int count);
    for (int p = first; p < first + count; p++) begin
      int idx = p % int'(cfg_list_len);
      for (int w = 0; w < int'(psize(idx)) / 4; w++) expq.push_back(memf(pbase(idx) + 32'(w * 4)));
    end
  endtask

  // model and stimulus state, all handled at the falling edge
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] pend_m = '0, clr_prev = '0, ev_prev = '0;
  int  pidx_m = 0, bp_m = 0, nhs = 0, nreq = 0;
  bit  dsel = 0, hs_prev = 0, req_pend = 0, hold_prev = 0, clr_en = 1;
  logic [31:0] req_addr = '0, hold_addr = '0;

  always @(negedge clk) begin
    logic [31:0] pend_old;
    logic [15:0] sz;
    if (!rst_n) begin
      pend_m = '0; clr_prev = '0; ev_prev = '0; pidx_m = 0; bp_m = 0;
      dsel = 0; hs_prev = 0; req_pend = 0; hold_prev = 0;
      mrsp_valid = 0; pend_clr_we = 0; mrq_ready = 0; smp_ready = 0;
    end else begin
      // R4: pending request held
      if (hold_prev) chk(mrq_valid && mrq_addr == hold_addr, "R4 request hold", mrq_addr, hold_addr);
      // pending register model
      pend_old = pend_m;
      pend_m = (pend_m & ~clr_prev) | ev_prev;
      if (ev_prev[0])  chk(pend[0],  "R5 half period bit",  pend, pend_m);
      if (ev_prev[4])  chk(pend[4],  "R6 full period bit",  pend, pend_m);
      if (ev_prev[8])  chk(pend[8],  "R7 half buffer bit",  pend, pend_m);
      if (ev_prev[12]) chk(pend[12], "R7 full buffer bit",  pend, pend_m);
      if (ev_prev[24]) chk(pend[24], "R8 end of audio bit", pend, pend_m);
      chk(pend == pend_m, "R9 pending register", pend, pend_m);
      chk(irq == |(pend_old & cfg_mask), "R10 irq", 32'(irq), 32'(|(pend_old & cfg_mask)));
      if (hs_prev) begin
        chk(byte_ptr == 16'(bp_m), "R3 byte position", 32'(byte_ptr), 32'(bp_m));
        if (ev_prev[4]) chk(byte_ptr == 0, "R6 byte position reload", 32'(byte_ptr), 0);
        chk(list_ptr == 6'(pidx_m), "R7 list index", 32'(list_ptr), 32'(pidx_m));
      end
      // memory response drive
      if (mrsp_valid && mrsp_ready) mrsp_valid = 0;
      if (req_pend) begin mrsp_valid = 1; mrsp_data = memf(req_addr); req_pend = 0; end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mrq_ready = lfsr[0] | lfsr[3];
      smp_ready = lfsr[5] | lfsr[9];
      clr_prev = '0;
      pend_clr_we = clr_en && (cyc % 5 == 0);
      pend_clr_data = {lfsr, lfsr[7:0], lfsr[15:8]};
      if (pend_clr_we) clr_prev = pend_clr_data;
      ev_prev = '0;
      hs_prev = 0;
      #1;
      hold_prev = mrq_valid && !mrq_ready;
      hold_addr = mrq_addr;
      if (mrq_valid && mrq_ready) begin
        req_pend = 1; req_addr = mrq_addr; nreq++;
        if (mrq_addr >= LBASE && mrq_addr < LBASE + 32'd64) begin
          logic [31:0] ea;
          ea = LBASE + 32'(pidx_m) * 8 + (dsel ? 32'd4 : 32'd0);
          chk(mrq_addr == ea, "R2 descriptor address", mrq_addr, ea);
          dsel = !dsel;
        end else begin
          logic [31:0] sa;
          sa = pbase(pidx_m) + 32'(bp_m);
          chk(mrq_addr == sa, "R3 sample address", mrq_addr, sa);
        end
      end
      if (smp_valid && smp_ready) begin
        nhs++;
        hs_prev = 1;
        if (expq.size() == 0) chk(0, "R3 unexpected sample", smp_data, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(smp_data == e, "R3 sample data", smp_data, e);
        end
        sz = psize(pidx_m);
        bp_m += 4;
        if (bp_m == int'(sz) / 2) ev_prev[0] = 1;
        if (cfg_stop_en && bp_m == int'(cfg_end_addr)) ev_prev[24] = 1;
        if (bp_m == int'(sz)) begin
          ev_prev[4] = 1;
          if (pidx_m == int'(cfg_list_len) / 2 - 1) ev_prev[8] = 1;
          if (pidx_m == int'(cfg_list_len) - 1) begin ev_prev[12] = 1; pidx_m = 0; end
          else pidx_m++;
          bp_m = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", 0, 0);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic do_reset();
    waitn(1);
    rst_n = 0;
    cfg_start = 0;
    #1;
    chk(pend == 0 && irq == 0, "R1 reset pend/irq", pend, 0);
    chk(list_ptr == 0 && byte_ptr == 0, "R1 reset pointers", {10'd0, list_ptr, byte_ptr}, 0);
    chk(!mrq_valid, "R1 reset request", 32'(mrq_valid), 0);
    waitn(3);
    rst_n = 1;
  endtask

  initial begin
    int snap, guard;
    // run 1: two full passes through a four-entry ring
    expq.delete();
    cfg_list_len = 6'd4; cfg_stop_en = 0; cfg_mask = 32'h0100_1111;
    do_reset();
    push_periods(0, 8);
    waitn(2);
    cfg_start = 1;
    guard = 0;
    while (expq.size() != 0 && guard < 20000) begin waitn(1); guard++; end
    chk(expq.size() == 0, "R7 two passes delivered", 32'(expq.size()), 0);
    cfg_start = 0;
    waitn(20);

    // run 2: stop position at byte 32 of entry 0
    cfg_stop_en = 1; cfg_end_addr = 16'd32; cfg_mask = 32'h0100_0000;
    do_reset();
    expq.delete();
    for (int w = 0; w < 8; w++) expq.push_back(memf(pbase(0) + 32'(w * 4)));
    waitn(2);
    cfg_start = 1;
    guard = 0;
    while (!pend_m[24] && guard < 5000) begin waitn(1); guard++; end
    chk(pend_m[24], "R8 end of audio reached", pend, 32'h0100_0000);
    waitn(2);
    snap = nreq;
    waitn(60);
    chk(nreq == snap && !mrq_valid, "R8 no request after halt", 32'(nreq), 32'(snap));
    chk(byte_ptr == 16'd32, "R8 halted position", 32'(byte_ptr), 32);
    chk(expq.size() == 0, "R8 samples before halt", 32'(expq.size()), 0);
    cfg_start = 0;
    waitn(5);

    // run 3: start dropped in the middle of a period
    cfg_stop_en = 0; cfg_mask = 32'h0000_0010;
    do_reset();
    expq.delete();
    push_periods(0, 8);
    waitn(2);
    cfg_start = 1;
    guard = 0;
    while (nhs < 20 && guard < 5000) begin waitn(1); guard++; end
    nhs = 0;
    waitn(1);
    cfg_start = 0;
    waitn(30);
    snap = nreq;
    waitn(40);
    chk(nreq == snap && !mrq_valid, "R11 quiet after stop", 32'(nreq), 32'(snap));
    chk(byte_ptr == 16'(bp_m), "R11 position kept", 32'(byte_ptr), 32'(bp_m));
    chk(list_ptr == 6'(pidx_m), "R11 index kept", 32'(list_ptr), 32'(pidx_m));

    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

endmodule